// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block paces a multiplexed external memory bus for a small 8-bit controller core. It runs directly from the oscillator clock. Each machine cycle lasts twelve oscillator clocks, made of six states of two clocks each. In every machine cycle the block produces an address-latch strobe that is active high and a program-store read strobe that is active low. It also selects where the low and high address bytes come from, and it drives those two bytes.

At the last clock of each machine cycle the block samples what the next cycle will be, and that choice holds for the whole cycle. A code fetch goes to external memory in two cases: the internal-program-memory enable pin is low, or the program counter lies above the internal boundary. Otherwise the fetch is internal. The latch strobe keeps a fixed cadence of two pulses per cycle, whatever the fetch source.

A data-access cycle needs its own address on the bus, so it drops the second latch pulse and both read-strobe pulses. For wide (16-bit) data addressing, the high address byte comes from the data address. For narrow (8-bit) addressing, the high byte carries the port 2 register value.

Top module: `xbus_seq`

## Requirements
- R1: While `rst` is high, `ale` is 0, `psenN` is 1, `loSel` and `hiSel` are 0, and `addrLo` and `addrHi` are 0.
- R2: A machine cycle is 12 clocks. Clock index 0 is the first clock after the sampling edge. In a fetch cycle, `ale` is 1 at indices 0, 1, 6 and 7 and 0 at the other indices, for internal and external fetches alike.
- R3: In an external fetch cycle, `psenN` is 0 at indices 2, 3, 8 and 9, which are the states that follow each latch pulse, and 1 at the other indices.
- R4: In an internal fetch cycle, `psenN` stays 1 for all 12 clocks.
- R5: A fetch is external when `intRomEn` is 0, or when `pc` is greater than 16'h3FFF. So with `intRomEn` at 1, `pc` = 16'h3FFF is internal and 16'h4000 is external.
- R6: In a data cycle (`dataReq` = 1 when sampled), `ale` is 1 only at indices 0 and 1, so the second pulse is skipped. `psenN` stays 1 for the whole cycle.
- R7: In a data cycle, `loSel` = 1 and `addrLo` = `dataAddr[7:0]`. With `dataWide` = 1, `hiSel` = 1 and `addrHi` = `dataAddr[15:8]`. With `dataWide` = 0, `hiSel` = 2 and `addrHi` = `port2Reg`.
- R8: In a fetch cycle, `loSel` = `hiSel` = 0, `addrLo` = `pc[7:0]` and `addrHi` = `pc[15:8]`.
- R9: Inputs are sampled only at the clock edge that ends a cycle (index 11). Changing them during a cycle does not affect that cycle's strobes or address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| intRomEn | input | 1 | 1 allows internal fetches below the boundary; 0 forces every fetch external |
| pc | input | 16 | Program counter of the next fetch |
| dataReq | input | 1 | Next cycle is an external data access |
| dataWide | input | 1 | Data access uses 16-bit addressing |
| dataAddr | input | 16 | Data address (narrow accesses use the low byte) |
| port2Reg | input | 8 | Port 2 register value |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program store read strobe, active low |
| loSel | output | 2 | Low byte source: 0 program counter, 1 data address |
| hiSel | output | 2 | High byte source: 0 program counter, 1 data address, 2 port 2 register |
| addrLo | output | 8 | Low address byte |
| addrHi | output | 8 | High address byte |

## Verification
A wrong cycle counter shows within one machine cycle: the latch pulses drift off indices 0 and 6, or they stretch past two clocks. A wrongly sampled cycle kind, or a wrong fetch-source decision, shows in the first cycle that uses it. It appears as a read pulse that should be missing (or the reverse), as a kept second latch pulse, or as the wrong high-byte source. The bench compares all outputs at every clock of every cycle. It also scrambles the inputs in the middle of each cycle, so a sampling fault shows in that same cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    SEL_PC   = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PORT = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic    load;
    srcSel_e loSel;
    srcSel_e hiSel;
  } busCtl_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int CLKS_PER_STATE = 2,
  parameter int STATES = 6,
  parameter logic [AW-1:0] INT_TOP = 16'h3FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          intRomEn,
  input  logic [AW-1:0] pc,
  input  logic          dataReq,
  input  logic          dataWide,
  output logic          ale,
  output logic          psenN,
  output busCtl_t       ctl
);
  localparam int CYC  = CLKS_PER_STATE * STATES;
  localparam int CW   = $clog2(CYC);
  localparam int SW   = $clog2(STATES);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);
  localparam logic [SW-1:0] ALE_A = '0;
  localparam logic [SW-1:0] ALE_B = SW'(STATES / 2);

  logic [CW-1:0] cnt;
  logic [SW-1:0] stateIdx;
  logic isData, isWide, fetchExt, load;

  assign load     = (cnt == LAST);
  assign stateIdx = SW'(cnt / CW'(CLKS_PER_STATE));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= LAST;
      isData   <= 1'b0;
      isWide   <= 1'b0;
      fetchExt <= 1'b0;
    end else begin
      cnt <= load ? '0 : cnt + 1'b1;
      if (load) begin
        isData   <= dataReq;
        isWide   <= dataWide;
        fetchExt <= !intRomEn || (pc > INT_TOP);
      end
    end
  end

  always_comb begin
    ale   = (stateIdx == ALE_A) || (!isData && stateIdx == ALE_B);
    psenN = !(!isData && fetchExt &&
              (stateIdx == ALE_A + 1'b1 || stateIdx == ALE_B + 1'b1));
    ctl.load  = load;
    ctl.loSel = isData ? SEL_DATA : SEL_PC;
    ctl.hiSel = isData ? (isWide ? SEL_DATA : SEL_PORT) : SEL_PC;
  end

  // R2: each latch pulse lasts exactly one state (two clocks)
  a_r2_ale_holds: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale);
  a_r2_ale_ends: assert property (@(posedge clk) disable iff (rst)
    (ale && $past(ale)) |=> !ale);
  // R3: a read strobe only ever starts right after a latch pulse
  a_r3_psen_after_ale: assert property (@(posedge clk) disable iff (rst)
    $fell(psenN) |-> $past(ale));
  // R6: the latch and read strobes are never active together
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psenN));
  // R9: the cycle kind stays fixed inside a machine cycle
  a_r9_kind_stable: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> ($stable(isData) && $stable(fetchExt) && $stable(isWide)));
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  busCtl_t       ctl,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] dataAddr,
  input  logic [BW-1:0] port2Reg,
  output logic [BW-1:0] addrLo,
  output logic [BW-1:0] addrHi
);
  logic [AW-1:0] pcQ, dataQ;
  logic [BW-1:0] portQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ   <= '0;
      dataQ <= '0;
      portQ <= '0;
    end else if (ctl.load) begin
      pcQ   <= pc;
      dataQ <= dataAddr;
      portQ <= port2Reg;
    end
  end

  always_comb begin
    addrLo = (ctl.loSel == SEL_DATA) ? dataQ[BW-1:0] : pcQ[BW-1:0];
    unique case (ctl.hiSel)
      SEL_DATA: addrHi = dataQ[2*BW-1:BW];
      SEL_PORT: addrHi = portQ;
      default:  addrHi = pcQ[2*BW-1:BW];
    endcase
  end

  // R9: address bytes only move at a cycle boundary
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable({addrLo, addrHi}));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int CLKS_PER_STATE = 2,
  parameter int STATES = 6,
  parameter logic [AW-1:0] INT_TOP = 16'h3FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          intRomEn,
  input  logic [AW-1:0] pc,
  input  logic          dataReq,
  input  logic          dataWide,
  input  logic [AW-1:0] dataAddr,
  input  logic [BW-1:0] port2Reg,
  output logic          ale,
  output logic          psenN,
  output logic [1:0]    loSel,
  output logic [1:0]    hiSel,
  output logic [BW-1:0] addrLo,
  output logic [BW-1:0] addrHi
);
  busCtl_t ctl;

  xbus_ctrl #(.AW(AW), .CLKS_PER_STATE(CLKS_PER_STATE), .STATES(STATES),
              .INT_TOP(INT_TOP)) ctrl_i (
    .clk(clk), .rst(rst), .intRomEn(intRomEn), .pc(pc),
    .dataReq(dataReq), .dataWide(dataWide),
    .ale(ale), .psenN(psenN), .ctl(ctl)
  );

  xbus_dpath #(.AW(AW), .BW(BW)) dpath_i (
    .clk(clk), .rst(rst), .ctl(ctl), .pc(pc), .dataAddr(dataAddr),
    .port2Reg(port2Reg), .addrLo(addrLo), .addrHi(addrHi)
  );

  assign loSel = ctl.loSel;
  assign hiSel = ctl.hiSel;
endmodule

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic intRomEn = 1'b0, dataReq = 1'b0, dataWide = 1'b0;
  logic [15:0] pc = '0, dataAddr = '0;
  logic [7:0] port2Reg = '0;
  logic ale, psenN;
  logic [1:0] loSel, hiSel;
  logic [7:0] addrLo, addrHi;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [21:0] vec;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  xbus_seq dut_i (
    .clk(clk), .rst(rst), .intRomEn(intRomEn), .pc(pc), .dataReq(dataReq),
    .dataWide(dataWide), .dataAddr(dataAddr), .port2Reg(port2Reg),
    .ale(ale), .psenN(psenN), .loSel(loSel), .hiSel(hiSel),
    .addrLo(addrLo), .addrHi(addrHi)
  );

  function automatic logic [21:0] pack(logic a, logic p, logic [1:0] ls,
                                       logic [1:0] hs, logic [7:0] lo,
                                       logic [7:0] hi);
    return {a, p, ls, hs, lo, hi};
  endfunction

  task automatic check(string tag, logic [21:0] act, logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: sets the inputs for the next cycle, queues 12 expected items,
  // then scrambles the inputs mid-cycle (R9).
  task automatic doCycle(logic dreq, logic wide, logic rom,
                         logic [15:0] pcV, logic [15:0] daV, logic [7:0] p2V);
    dataReq = dreq; dataWide = wide; intRomEn = rom;
    pc = pcV; dataAddr = daV; port2Reg = p2V;
    for (int k = 0; k < 12; k++) begin
      int s;
      exp_t e;
      logic ext;
      s = k / 2;
      ext = !rom || (pcV > 16'h3FFF);
      if (dreq) begin
        e.vec = pack(s == 0, 1'b1, 2'd1, wide ? 2'd1 : 2'd2, daV[7:0],
                     wide ? daV[15:8] : p2V);
        e.tag = "R6 R7 R9 data";
      end else begin
        e.vec = pack(s == 0 || s == 3, !(ext && (s == 1 || s == 4)),
                     2'd0, 2'd0, pcV[7:0], pcV[15:8]);
        e.tag = ext ? "R2 R3 R5 R8 R9 ext fetch" : "R2 R4 R5 R8 R9 int fetch";
      end
      q.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
    dataReq = !dreq; dataWide = !wide; intRomEn = !rom;
    pc = ~pcV; dataAddr = ~daV; port2Reg = ~p2V;
    repeat (11) @(negedge clk);
  endtask

  // Monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, pack(ale, psenN, loSel, hiSel, addrLo, addrHi), e.vec);
      end
    end
  end

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobes", {20'd0, ale, psenN}, {20'd0, 1'b0, 1'b1});
    check("R1 reset selects", {18'd0, loSel, hiSel}, 22'd0);
    check("R1 reset address", {6'd0, addrLo, addrHi}, 22'd0);
    rst = 1'b0;
    doCycle(1'b0, 1'b0, 1'b1, 16'h1234, 16'h0, 8'h00);  // internal fetch
    doCycle(1'b0, 1'b0, 1'b0, 16'h0010, 16'h0, 8'h00);  // pin forces external
    doCycle(1'b0, 1'b0, 1'b1, 16'h3FFF, 16'h0, 8'h00);  // R5 boundary internal
    doCycle(1'b0, 1'b0, 1'b1, 16'h4000, 16'h0, 8'h00);  // R5 boundary external
    doCycle(1'b1, 1'b1, 1'b1, 16'h0100, 16'hBEEF, 8'h5A); // R7 wide data
    doCycle(1'b1, 1'b0, 1'b0, 16'h0100, 16'h0077, 8'hC3); // R7 narrow data
    doCycle(1'b1, 1'b1, 1'b0, 16'h0100, 16'hA55A, 8'h11); // back-to-back data
    doCycle(1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h1111, 8'h22); // top of space
    doCycle(1'b0, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 8'hFF); // bottom, internal
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule